// File: doc/BRIEF.md
# Comma-Aligned Serial-to-Word Receiver

This block sits behind a clock-and-data recovery front end. It takes a retimed serial stream, one bit per recovered bit clock, and rebuilds 10-bit words from it. The first bit received in a word becomes bit 0 of the word. The block looks for the positive-disparity comma pattern in the incoming bits. When alignment is enabled, it moves its word boundary so that each comma starts a word.

Two byte clocks leave the block. Each runs at half the word rate, and the two are always opposite in phase. Successive words are presented on the rising edge of one clock and then the other, in turn. To realign, the block holds its internal divide-by-20 phase counter for a few bit periods. This only lengthens a clock phase and never shortens one. The hold is sized so that the comma that follows realignment lands on the rising edge of the second clock (`bclk_b`).

A signal-valid input marks when the front end sees a usable input. While it is low, every word presented is all ones. A flag marks each presented word that holds a comma.

Top module: `dsr_deser`

## Requirements
- R1: A comma is the bit sequence 0,0,1,1,1,1,1 in the first seven received bits of a word, which is `word_out[6:0] == 7'b1111100`. Bits 7 to 9 are don't-care. `comma_flag` is high exactly while the presented word holds a comma and `sig_ok` was high when that word was taken.
- R2: Bits are assembled least significant first. The earliest received bit of a word appears at `word_out[0]` and the latest at `word_out[9]`.
- R3: `bclk_a` and `bclk_b` are always complementary. Without realignment, each has a period of 20 bit clocks. `word_out` changes only on a rising edge of either byte clock. Words alternate between the two clocks.
- R4: No high or low phase of either byte clock is shorter than 10 bit clocks. Realignment only lengthens phases.
- R5: With `align_en` high, the comma that follows the first detected comma by 20 bits is presented on a rising edge of `bclk_b`. The non-comma word after it is presented on the next rising edge of `bclk_a`. This holds for every bit offset of the incoming stream.
- R6: With `align_en` low, the word boundary never moves. The first word after reset is formed from bits 0 to 9 captured after reset and is presented on `bclk_b`. Each later word takes the next 10 bits, whatever the data holds.
- R7: A word taken while `sig_ok` is low is presented as all ones (10'h3FF), with `comma_flag` low.
- R8: In reset, `word_out` is all ones, `bclk_a` is 1, `bclk_b` is 0 and `comma_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Retimed serial data, one bit per clock |
| align_en | input | 1 | Enables comma-based boundary realignment |
| sig_ok | input | 1 | Input signal valid; low forces all-ones words |
| word_out | output | 10 | Recovered parallel word, bit 0 received first |
| bclk_a | output | 1 | Byte clock A, half word rate |
| bclk_b | output | 1 | Byte clock B, inverse of A; commas land on its rising edge |
| comma_flag | output | 1 | High while the presented word holds a comma |

## Verification
A comma can complete on the same bit clock on which a word boundary for `bclk_a` was already due. Realignment then has to cancel that boundary and stretch the clock instead of presenting a misaligned word. The bench provokes this by sweeping the stream offset through all 20 positions, so that one offset puts the first comma on exactly that cycle. It judges the result by the word and clock edge seen at the following comma and by the measured length of every clock phase. Signal loss is also made to overlap a comma word, and the bench checks that the forced all-ones value wins over the comma flag.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    localparam int unsigned DEF_WORD_W = 10;
    localparam int unsigned DEF_MARK_W = 7;
    localparam logic [DEF_MARK_W-1:0] DEF_MARK = 7'b1111100;

    // Number of bit clocks the phase counter must freeze so that a mark seen
    // at count 'cnt' recurs one period later at count 'tgt'.
    function automatic int unsigned stretch_len(int unsigned cnt,
                                                int unsigned per,
                                                int unsigned tgt);
        int unsigned t;
        t = cnt + per - tgt;
        if (t >= per) t = t - per;
        return t;
    endfunction

endpackage

// File: rtl/dsr_shift.sv
module dsr_shift #(
    parameter int unsigned WORD_W = dsr_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic [WORD_W-1:0] win
);
    typedef struct packed {
        logic [WORD_W-1:0] bits;
    } sh_t;

    sh_t sh_q, sh_d;

    // Newest bit enters at the top, so the oldest sits at bit 0.
    always_comb begin
        sh_d      = sh_q;
        sh_d.bits = {ser_in, sh_q.bits[WORD_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '{bits: '1};
        else        sh_q <= sh_d;
    end

    assign win = sh_d.bits;
endmodule

// File: rtl/dsr_mark_det.sv
module dsr_mark_det #(
    parameter int unsigned            MARK_W = dsr_pkg::DEF_MARK_W,
    parameter logic [MARK_W-1:0]      MARK   = dsr_pkg::DEF_MARK
) (
    input  logic [MARK_W-1:0] win_lo,
    output logic              hit
);
    logic [MARK_W-1:0] eq;

    for (genvar g = 0; g < MARK_W; g++) begin : g_bit
        assign eq[g] = (win_lo[g] == MARK[g]);
    end

    assign hit = &eq;
endmodule

// File: rtl/dsr_phase.sv
module dsr_phase #(
    parameter int unsigned WORD_W = dsr_pkg::DEF_WORD_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic align_en,
    input  logic mark_hit,
    output logic bclk_a,
    output logic bclk_b,
    output logic word_end
);
    localparam int unsigned PER  = 2 * WORD_W;
    localparam int unsigned CW   = $clog2(PER);
    localparam logic [CW-1:0] LAST_A = CW'(PER - 1);
    localparam logic [CW-1:0] LAST_B = CW'(WORD_W - 1);
    localparam logic [CW-1:0] HALF   = CW'(WORD_W);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] hold;
        logic          hi_a;
    } ph_t;

    ph_t         ph_q, ph_d;
    logic        end_d;
    int unsigned gap_d;

    always_comb begin
        ph_d  = ph_q;
        end_d = 1'b0;
        gap_d = dsr_pkg::stretch_len(32'(ph_q.cnt), PER, WORD_W - 1);
        if (ph_q.hold != '0) begin
            ph_d.hold = ph_q.hold - 1'b1;           // counter frozen: stretch
        end else if (align_en && mark_hit && (ph_q.cnt != LAST_B)) begin
            ph_d.hold = CW'(gap_d - 1);             // this cycle is the first held one
        end else begin
            end_d    = (ph_q.cnt == LAST_A) || (ph_q.cnt == LAST_B);
            ph_d.cnt = (ph_q.cnt == LAST_A) ? '0 : ph_q.cnt + 1'b1;
        end
        ph_d.hi_a = (ph_d.cnt < HALF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '{cnt: '0, hold: '0, hi_a: 1'b1};
        else        ph_q <= ph_d;
    end

    assign bclk_a   = ph_q.hi_a;
    assign bclk_b   = ~ph_q.hi_a;
    assign word_end = end_d;
endmodule

// File: rtl/dsr_deser.sv
module dsr_deser #(
    parameter int unsigned       WORD_W = dsr_pkg::DEF_WORD_W,
    parameter int unsigned       MARK_W = dsr_pkg::DEF_MARK_W,
    parameter logic [MARK_W-1:0] MARK   = dsr_pkg::DEF_MARK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              align_en,
    input  logic              sig_ok,
    output logic [WORD_W-1:0] word_out,
    output logic              bclk_a,
    output logic              bclk_b,
    output logic              comma_flag
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              flag;
    } out_t;

    logic [WORD_W-1:0] win;
    logic              hit;
    logic              word_end;
    out_t              out_q, out_d;

    dsr_shift #(.WORD_W(WORD_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .ser_in(ser_in),
        .win   (win)
    );

    dsr_mark_det #(.MARK_W(MARK_W), .MARK(MARK)) u_det (
        .win_lo(win[MARK_W-1:0]),
        .hit   (hit)
    );

    dsr_phase #(.WORD_W(WORD_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .align_en(align_en),
        .mark_hit(hit),
        .bclk_a  (bclk_a),
        .bclk_b  (bclk_b),
        .word_end(word_end)
    );

    always_comb begin
        out_d = out_q;
        if (word_end) begin
            out_d.word = sig_ok ? win : '1;
            out_d.flag = sig_ok & hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '{word: '1, flag: 1'b0};
        else        out_q <= out_d;
    end

    assign word_out   = out_q.word;
    assign comma_flag = out_q.flag;
endmodule

// File: rtl/dsr_deser_chk.sv
module dsr_deser_chk #(
    parameter int unsigned       WORD_W = dsr_pkg::DEF_WORD_W,
    parameter int unsigned       MARK_W = dsr_pkg::DEF_MARK_W,
    parameter logic [MARK_W-1:0] MARK   = dsr_pkg::DEF_MARK
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sig_ok,
    input logic [WORD_W-1:0] word_out,
    input logic              bclk_a,
    input logic              bclk_b,
    input logic              comma_flag
);
    logic       prev_a_q;
    logic [7:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_a_q <= 1'b1;
            run_q    <= 8'hFF;
        end else begin
            prev_a_q <= bclk_a;
            if (bclk_a != prev_a_q)  run_q <= 8'd1;
            else if (run_q != 8'hFF) run_q <= run_q + 8'd1;
        end
    end

    AST_CLK_OPPOSED: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_a != bclk_b);                                                  // R3

    AST_WORD_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(bclk_a) || $rose(bclk_b)) |-> $stable(word_out));           // R3

    AST_MIN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_a != prev_a_q) |-> (run_q >= 8'(WORD_W)));                   // R4

    AST_FORCED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (($rose(bclk_a) || $rose(bclk_b)) && !$past(sig_ok))
        |-> (word_out == {WORD_W{1'b1}} && !comma_flag));                   // R7

    AST_FLAG_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        comma_flag |-> (word_out[MARK_W-1:0] == MARK));                     // R1
endmodule

bind dsr_deser dsr_deser_chk #(.WORD_W(WORD_W), .MARK_W(MARK_W), .MARK(MARK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_ok    (sig_ok),
    .word_out  (word_out),
    .bclk_a    (bclk_a),
    .bclk_b    (bclk_b),
    .comma_flag(comma_flag)
);

// File: tb/dsr_deser_bench.sv
`timescale 1ns/1ps
module dsr_deser_bench;
    localparam logic [9:0] MARK_WORD = 10'h17C;   // bits 0..9: 0,0,1,1,1,1,1,0,1,0
    localparam logic [9:0] FILL_WORD = 10'h155;   // bits 0..9: 1,0,1,0,...
    localparam logic [9:0] ONES      = 10'h3FF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       align_en = 1'b1;
    logic       sig_ok = 1'b1;
    logic [9:0] word_out;
    logic       bclk_a, bclk_b, comma_flag;

    int n_chk = 0;
    int n_bad = 0;
    logic bits [0:511];
    logic okv  [0:511];
    int nbits;
    int mode;
    int k_off;
    logic pa, pb;
    int viol;
    int run_len;
    logic pa_m;

    always #2.5 clk = ~clk;

    dsr_deser u_dsr_deser (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .align_en(align_en),
        .sig_ok(sig_ok), .word_out(word_out), .bclk_a(bclk_a),
        .bclk_b(bclk_b), .comma_flag(comma_flag)
    );

    // Independent phase-length monitor (R4)
    always @(negedge clk) begin
        if (!rst_n) begin
            run_len = 100;
            pa_m    = 1'b1;
        end else begin
            if (bclk_a != pa_m) begin
                if (run_len < 10) viol++;
                run_len = 1;
            end else begin
                run_len++;
            end
            pa_m = bclk_a;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [9:0] act,
                       input logic [9:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (offset %0d)", req, act, exp, k_off);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ser_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        viol = 0;
        pa = 1'b1;
        pb = 1'b0;
    endtask

    task automatic obs(input int idx);
        logic ra, rb;
        int   rel;
        logic [9:0] exp_w;
        ra = bclk_a && !pa;
        rb = bclk_b && !pb;
        pa = bclk_a;
        pb = bclk_b;
        if (mode == 0) begin
            rel = idx - k_off - 9;
            if (rel >= 20 && rel % 20 == 0) begin
                exp_w = okv[idx] ? MARK_WORD : ONES;
                chk(rb, "R5 comma on bclk_b rise", {9'd0, rb}, 10'd1);
                chk(word_out == exp_w, okv[idx] ? "R5 comma word" : "R7 forced ones",
                    word_out, exp_w);
                chk(comma_flag == okv[idx], "R1 comma flag", {9'd0, comma_flag},
                    {9'd0, okv[idx]});
            end else if (rel >= 30 && rel % 20 == 10) begin
                exp_w = okv[idx] ? FILL_WORD : ONES;
                chk(ra, "R3 data on bclk_a rise", {9'd0, ra}, 10'd1);
                chk(word_out == exp_w, okv[idx] ? "R3 data word" : "R7 forced ones",
                    word_out, exp_w);
                chk(!comma_flag, "R1 flag low on data", {9'd0, comma_flag}, 10'd0);
            end
        end else begin
            if (idx % 20 == 9)
                chk(rb, "R6 fixed boundary bclk_b", {9'd0, rb}, 10'd1);
            if (idx % 20 == 19)
                chk(ra, "R6 fixed boundary bclk_a", {9'd0, ra}, 10'd1);
            if (idx % 10 == 9) begin
                for (int j = 0; j < 10; j++) exp_w[j] = bits[idx - 9 + j];
                chk(word_out == exp_w, "R2 R6 bit order and slice", word_out, exp_w);
                chk(comma_flag == (exp_w[6:0] == 7'b1111100), "R1 flag on fixed slice",
                    {9'd0, comma_flag}, {9'd0, exp_w[6:0] == 7'b1111100});
            end
        end
    endtask

    task automatic play();
        for (int i = 0; i <= nbits; i++) begin
            if (i > 0) obs(i - 1);
            if (i < nbits) begin
                ser_in = bits[i];
                sig_ok = okv[i];
            end
            @(negedge clk);
        end
        chk(viol == 0, "R4 min phase", viol[9:0], 10'd0);
    endtask

    task automatic build_sets(input int k);
        k_off = k;
        nbits = 0;
        for (int i = 0; i < k; i++) begin
            bits[nbits] = (i % 2 == 0);
            okv[nbits]  = 1'b1;
            nbits++;
        end
        for (int s = 0; s < 5; s++) begin
            for (int j = 0; j < 10; j++) begin
                bits[nbits] = MARK_WORD[j]; okv[nbits] = 1'b1; nbits++;
            end
            for (int j = 0; j < 10; j++) begin
                bits[nbits] = FILL_WORD[j]; okv[nbits] = 1'b1; nbits++;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(word_out == ONES, "R8 reset word", word_out, ONES);
        chk(bclk_a == 1'b1 && bclk_b == 1'b0, "R8 reset clocks",
            {8'd0, bclk_a, bclk_b}, 10'b10);
        chk(comma_flag == 1'b0, "R8 reset flag", {9'd0, comma_flag}, 10'd0);
    endtask

    task automatic t_offsets();
        mode = 0;
        align_en = 1'b1;
        for (int k = 0; k < 20; k++) begin
            build_sets(k);
            do_reset();
            play();
        end
    endtask

    task automatic t_align_off();
        logic [15:0] lf;
        mode = 0;
        mode = 1;
        align_en = 1'b0;
        k_off = 0;
        lf = 16'hACE1;
        nbits = 200;
        for (int i = 0; i < nbits; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            bits[i] = lf[0];
            okv[i]  = 1'b1;
        end
        for (int j = 0; j < 10; j++) bits[33 + j] = MARK_WORD[j];   // misaligned comma
        for (int j = 0; j < 10; j++) bits[120 + j] = MARK_WORD[j];  // aligned comma
        do_reset();
        play();
        align_en = 1'b1;
    endtask

    task automatic t_sig_loss();
        mode = 0;
        align_en = 1'b1;
        build_sets(7);
        for (int i = 7 + 9 + 40 - 12; i <= 7 + 9 + 50; i++) okv[i] = 1'b0;
        do_reset();
        play();
        sig_ok = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        viol = 0;
        t_reset();
        t_offsets();
        t_align_off();
        t_sig_loss();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule